// File: doc/BRIEF.md
# SPI FIFO Watermark Interrupt Controller

This block keeps the transmit and receive data queues of an SPI peripheral and produces the interrupt request for them. Each queue stores up to 64 bits as single bytes. A byte access moves 8 bits and a 16-bit word access moves 16 bits. The register bus fills the transmit queue and drains the receive queue. The shift engine does the reverse. The block reports the occupancy of each queue in bits. From those occupancies it derives a data-available flag, a transmit-empty flag, a transmit nearly-empty flag and a receive nearly-full flag. The two watermark thresholds can be selected.

A six-bit control register turns FIFO mode on and off, picks both watermarks, enables the two watermark interrupts and selects how interrupts are cleared. When FIFO mode is off, each queue acts as a 16-bit buffer. In auto-clear mode an interrupt source follows its live flag. In write-to-clear mode each source has a two-state machine. The state `SRC_IDLE` moves to `SRC_LATCHED` on a rising flag (transition RISE_LATCH). It returns to `SRC_IDLE` only when software writes a one to the matching bit of the clear strobe and no new rise happens in that cycle (transition ACK_CLEAR). If a rise and a clear arrive in the same cycle, the state stays in `SRC_LATCHED` (transition RISE_WINS).

Top module: `spi_fifo_irq_ctrl`

## Requirements
- R1: The control register resets to 0. It stores write bits [5:0] as follows: [5] transmit watermark select, [4] receive watermark select, [3] clear mode, [2] transmit nearly-empty enable, [1] receive nearly-full enable, [0] FIFO mode. Read bits [7:6] are always 0.
- R2: The queue level is counted in bits. A byte push adds 8 and a word push adds 16. Pops subtract the same amounts. Data leaves in arrival order. A word is stored low byte first, a word pop returns {second byte, first byte}, and a byte pop returns the byte in bits [7:0] with bits [15:8] at 0.
- R3: Capacity is 64 bits in FIFO mode and 16 bits when FIFO mode is off. A push that would exceed the capacity is ignored and sets a sticky overflow output.
- R4: A pop that asks for more bytes than the queue holds is ignored and sets a sticky underflow output.
- R5: The transmit nearly-empty flag is 1 when the transmit level is at most 16 bits (select 0) or at most 32 bits (select 1).
- R6: The receive nearly-full flag is 1 when the receive level is at least 48 bits (select 0) or at least 32 bits (select 1).
- R7: The data-available flag is 1 when the receive level is not zero. The transmit-empty flag is 1 when the transmit level is zero.
- R8: When FIFO mode is 0, the two watermark interrupt enables have no effect on `irq`.
- R9: With clear mode 0, each pending bit equals its live flag. The bit order is [0] data-available, [1] transmit-empty, [2] nearly-empty, [3] nearly-full.
- R10: With clear mode 1, a pending bit sets on the clock edge after the edge on which its flag rises. It then stays set, even after the flag falls, until `clr_we` is pulsed with that bit of `clr_wdata` at 1. Other pending bits are not affected.
- R11: If a clear write lands in the same cycle as a newly seen rise of that flag, the pending bit stays set.
- R12: `irq` is the OR of each pending bit ANDed with its enable. The enables are `rx_data_ie`, `tx_empty_ie`, and the two watermark enables gated by FIFO mode.
- R13: A control write that changes the FIFO-mode bit empties both queues. Their levels read 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register read value |
| clr_we | input | 1 | Interrupt clear write strobe |
| clr_wdata | input | 4 | Write-one-to-clear bits, same order as `irq_pending` |
| rx_data_ie | input | 1 | Data-available interrupt enable |
| tx_empty_ie | input | 1 | Transmit-empty interrupt enable |
| tx_push | input | 1 | Bus push into transmit queue |
| tx_push_word | input | 1 | Transmit push size: 1 = word, 0 = byte |
| tx_push_data | input | 16 | Transmit push data |
| tx_pop | input | 1 | Shifter pop from transmit queue |
| tx_pop_word | input | 1 | Transmit pop size |
| tx_pop_data | output | 16 | Transmit head data |
| rx_push | input | 1 | Shifter push into receive queue |
| rx_push_word | input | 1 | Receive push size |
| rx_push_data | input | 16 | Receive push data |
| rx_pop | input | 1 | Bus pop from receive queue |
| rx_pop_word | input | 1 | Receive pop size |
| rx_pop_data | output | 16 | Receive head data |
| tx_level | output | 7 | Transmit occupancy in bits |
| rx_level | output | 7 | Receive occupancy in bits |
| tx_overflow | output | 1 | Sticky transmit overflow |
| tx_underflow | output | 1 | Sticky transmit underflow |
| rx_overflow | output | 1 | Sticky receive overflow |
| rx_underflow | output | 1 | Sticky receive underflow |
| rx_avail | output | 1 | Receive data-available flag |
| tx_empty | output | 1 | Transmit-empty flag |
| tx_near_empty | output | 1 | Transmit nearly-empty flag |
| rx_near_full | output | 1 | Receive nearly-full flag |
| irq_pending | output | 4 | Pending sources before enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a clear write that lands in exactly the cycle in which a source's state machine first sees its flag rise. The flag changes on the edge that takes the push, and the rise is registered one edge later. To hit this case, the bench pushes the byte that crosses the receive watermark and raises the clear strobe for that bit in the very next cycle. It then drops the strobe and checks that the pending bit survived. The watermark logic is also swept near-exhaustively. Every byte and word level is visited under both selects of each watermark, and the expected flag is computed from the level.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    typedef enum logic {
        SRC_IDLE    = 1'b0,
        SRC_LATCHED = 1'b1
    } src_state_e;

    localparam int SRC_RX_AVAIL = 0;
    localparam int SRC_TX_EMPTY = 1;
    localparam int SRC_TX_NEAR  = 2;
    localparam int SRC_RX_NEAR  = 3;
    localparam int NUM_SRC      = 4;

    typedef struct packed {
        logic tx_mark;
        logic rx_mark;
        logic clr_mode;
        logic tx_near_ie;
        logic rx_near_ie;
        logic fifo_en;
    } ctrl_t;

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int DEPTH_BYTES = 8,
    localparam int AW = $clog2(DEPTH_BYTES),
    localparam int CW = $clog2(DEPTH_BYTES + 1),
    localparam int LW = $clog2(DEPTH_BYTES * 8 + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [CW-1:0] cap_bytes,
    input  logic          push,
    input  logic          push_word,
    input  logic [15:0]   push_data,
    input  logic          pop,
    input  logic          pop_word,
    output logic [15:0]   pop_data,
    output logic [LW-1:0] level_bits,
    output logic          overflow,
    output logic          underflow
);

    logic [7:0]    mem [DEPTH_BYTES];
    logic [AW-1:0] head, tail;
    logic [CW-1:0] cnt;
    logic [CW-1:0] push_n, pop_n;
    logic          push_ok, pop_ok;

    always_comb begin
        push_n  = push_word ? CW'(2) : CW'(1);
        pop_n   = pop_word  ? CW'(2) : CW'(1);
        push_ok = push && (({1'b0, cnt} + {1'b0, push_n}) <= {1'b0, cap_bytes});
        pop_ok  = pop && (cnt >= pop_n);
    end

    // storage, no reset needed
    always_ff @(posedge clk) begin
        if (push_ok && !flush) begin
            mem[tail] <= push_data[7:0];
            if (push_word) begin
                mem[tail + AW'(1)] <= push_data[15:8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head      <= '0;
            tail      <= '0;
            cnt       <= '0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else if (flush) begin
            head <= '0;
            tail <= '0;
            cnt  <= '0;
        end else begin
            if (push_ok) tail <= tail + AW'(push_n);
            if (pop_ok)  head <= head + AW'(pop_n);
            cnt <= cnt + (push_ok ? push_n : CW'(0)) - (pop_ok ? pop_n : CW'(0));
            if (push && !push_ok) overflow  <= 1'b1;
            if (pop  && !pop_ok)  underflow <= 1'b1;
        end
    end

    always_comb begin
        pop_data   = pop_word ? {mem[head + AW'(1)], mem[head]} : {8'h00, mem[head]};
        level_bits = LW'({cnt, 3'b000});
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH_BYTES));

    assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush && (({1'b0, cnt} + {1'b0, push_n}) > {1'b0, cap_bytes})) |=> overflow);

    assert_underflow_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush && cnt < pop_n) |=> underflow);

    assert_flush_empties_R13: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt == '0));

endmodule

// File: rtl/spi_irq_source.sv
module spi_irq_source
    import spi_fifo_pkg::*;
#(
    parameter logic RST_FLAG = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag,
    input  logic clr,
    input  logic w1c_mode,
    output logic pending
);

    src_state_e state, state_nxt;
    logic       flag_q;
    logic       rise;

    assign rise = flag && !flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= SRC_IDLE;
            flag_q <= RST_FLAG;
        end else begin
            state  <= state_nxt;
            flag_q <= flag;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            SRC_IDLE:    if (rise)          state_nxt = SRC_LATCHED;   // RISE_LATCH
            SRC_LATCHED: if (clr && !rise)  state_nxt = SRC_IDLE;      // ACK_CLEAR, else RISE_WINS
            default:                        state_nxt = SRC_IDLE;
        endcase
    end

    always_comb begin
        pending = w1c_mode ? (state == SRC_LATCHED) : flag;
    end

    assert_latch_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (state == SRC_LATCHED));

    assert_hold_until_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SRC_LATCHED && !clr) |=> (state == SRC_LATCHED));

    assert_rise_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && rise) |=> (state == SRC_LATCHED));

endmodule

// File: rtl/spi_fifo_irq_ctrl.sv
module spi_fifo_irq_ctrl
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH_BYTES = 8,
    localparam int CW = $clog2(DEPTH_BYTES + 1),
    localparam int LW = $clog2(DEPTH_BYTES * 8 + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic [7:0]    ctrl_wdata,
    output logic [7:0]    ctrl_rdata,
    input  logic          clr_we,
    input  logic [3:0]    clr_wdata,
    input  logic          rx_data_ie,
    input  logic          tx_empty_ie,
    input  logic          tx_push,
    input  logic          tx_push_word,
    input  logic [15:0]   tx_push_data,
    input  logic          tx_pop,
    input  logic          tx_pop_word,
    output logic [15:0]   tx_pop_data,
    input  logic          rx_push,
    input  logic          rx_push_word,
    input  logic [15:0]   rx_push_data,
    input  logic          rx_pop,
    input  logic          rx_pop_word,
    output logic [15:0]   rx_pop_data,
    output logic [LW-1:0] tx_level,
    output logic [LW-1:0] rx_level,
    output logic          tx_overflow,
    output logic          tx_underflow,
    output logic          rx_overflow,
    output logic          rx_underflow,
    output logic          rx_avail,
    output logic          tx_empty,
    output logic          tx_near_empty,
    output logic          rx_near_full,
    output logic [3:0]    irq_pending,
    output logic          irq
);

    localparam int            CAP_BITS   = DEPTH_BYTES * 8;
    localparam logic [LW-1:0] TX_MARK_Q  = LW'(CAP_BITS / 4);
    localparam logic [LW-1:0] TX_MARK_H  = LW'(CAP_BITS / 2);
    localparam logic [LW-1:0] RX_MARK_3Q = LW'((CAP_BITS * 3) / 4);
    localparam logic [LW-1:0] RX_MARK_H  = LW'(CAP_BITS / 2);
    localparam logic [NUM_SRC-1:0] FLAG_RST = 4'b0110;

    ctrl_t               ctrl;
    logic                flush;
    logic [CW-1:0]       cap_bytes;
    logic [NUM_SRC-1:0]  flags;
    logic [NUM_SRC-1:0]  enables;
    logic [1:0]          unused_wdata_bits;

    assign unused_wdata_bits = ctrl_wdata[7:6];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (ctrl_we) begin
            ctrl <= ctrl_t'(ctrl_wdata[5:0]);
        end
    end

    always_comb begin
        ctrl_rdata = {2'b00, ctrl};
        flush      = ctrl_we && (ctrl_wdata[0] != ctrl.fifo_en);
        cap_bytes  = ctrl.fifo_en ? CW'(DEPTH_BYTES) : CW'(2);
    end

    spi_byte_fifo #(.DEPTH_BYTES(DEPTH_BYTES)) u_tx_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .cap_bytes  (cap_bytes),
        .push       (tx_push),
        .push_word  (tx_push_word),
        .push_data  (tx_push_data),
        .pop        (tx_pop),
        .pop_word   (tx_pop_word),
        .pop_data   (tx_pop_data),
        .level_bits (tx_level),
        .overflow   (tx_overflow),
        .underflow  (tx_underflow)
    );

    spi_byte_fifo #(.DEPTH_BYTES(DEPTH_BYTES)) u_rx_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .cap_bytes  (cap_bytes),
        .push       (rx_push),
        .push_word  (rx_push_word),
        .push_data  (rx_push_data),
        .pop        (rx_pop),
        .pop_word   (rx_pop_word),
        .pop_data   (rx_pop_data),
        .level_bits (rx_level),
        .overflow   (rx_overflow),
        .underflow  (rx_underflow)
    );

    always_comb begin
        rx_avail      = (rx_level != '0);
        tx_empty      = (tx_level == '0);
        tx_near_empty = tx_level <= (ctrl.tx_mark ? TX_MARK_H : TX_MARK_Q);
        rx_near_full  = rx_level >= (ctrl.rx_mark ? RX_MARK_H : RX_MARK_3Q);

        flags[SRC_RX_AVAIL] = rx_avail;
        flags[SRC_TX_EMPTY] = tx_empty;
        flags[SRC_TX_NEAR]  = tx_near_empty;
        flags[SRC_RX_NEAR]  = rx_near_full;

        enables[SRC_RX_AVAIL] = rx_data_ie;
        enables[SRC_TX_EMPTY] = tx_empty_ie;
        enables[SRC_TX_NEAR]  = ctrl.tx_near_ie && ctrl.fifo_en;
        enables[SRC_RX_NEAR]  = ctrl.rx_near_ie && ctrl.fifo_en;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        spi_irq_source #(.RST_FLAG(FLAG_RST[i])) u_src (
            .clk      (clk),
            .rst_n    (rst_n),
            .flag     (flags[i]),
            .clr      (clr_we && clr_wdata[i]),
            .w1c_mode (ctrl.clr_mode),
            .pending  (irq_pending[i])
        );
    end

    assign irq = |(irq_pending & enables);

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[7:6] == 2'b00);

    assert_marks_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.fifo_en && !rx_data_ie && !tx_empty_ie) |-> !irq);

    assert_levels_cleared_R13: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tx_level == '0 && rx_level == '0));

    assert_auto_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.clr_mode |-> (irq_pending[SRC_TX_EMPTY] == (tx_level == '0)));

endmodule

// File: tb/spi_fifo_irq_ctrl_bench.sv
module spi_fifo_irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 0;
    logic [7:0]  ctrl_wdata = 0;
    logic [7:0]  ctrl_rdata;
    logic        clr_we = 0;
    logic [3:0]  clr_wdata = 0;
    logic        rx_data_ie = 0, tx_empty_ie = 0;
    logic        tx_push = 0, tx_push_word = 0, tx_pop = 0, tx_pop_word = 0;
    logic        rx_push = 0, rx_push_word = 0, rx_pop = 0, rx_pop_word = 0;
    logic [15:0] tx_push_data = 0, rx_push_data = 0;
    logic [15:0] tx_pop_data, rx_pop_data;
    logic [6:0]  tx_level, rx_level;
    logic        tx_overflow, tx_underflow, rx_overflow, rx_underflow;
    logic        rx_avail, tx_empty, tx_near_empty, rx_near_full;
    logic [3:0]  irq_pending;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    spi_fifo_irq_ctrl u_spi_fifo_irq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .clr_we(clr_we), .clr_wdata(clr_wdata),
        .rx_data_ie(rx_data_ie), .tx_empty_ie(tx_empty_ie),
        .tx_push(tx_push), .tx_push_word(tx_push_word), .tx_push_data(tx_push_data),
        .tx_pop(tx_pop), .tx_pop_word(tx_pop_word), .tx_pop_data(tx_pop_data),
        .rx_push(rx_push), .rx_push_word(rx_push_word), .rx_push_data(rx_push_data),
        .rx_pop(rx_pop), .rx_pop_word(rx_pop_word), .rx_pop_data(rx_pop_data),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_overflow(tx_overflow), .tx_underflow(tx_underflow),
        .rx_overflow(rx_overflow), .rx_underflow(rx_underflow),
        .rx_avail(rx_avail), .tx_empty(tx_empty),
        .tx_near_empty(tx_near_empty), .rx_near_full(rx_near_full),
        .irq_pending(irq_pending), .irq(irq)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog act=running exp=finished");
        summary();
        $finish;
    end

    task automatic chk(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wctrl(input logic [7:0] v);
        ctrl_we = 1; ctrl_wdata = v; cyc(); ctrl_we = 0; cyc();
    endtask

    task automatic wclr(input logic [3:0] v);
        clr_we = 1; clr_wdata = v; cyc(); clr_we = 0; clr_wdata = 0; cyc();
    endtask

    task automatic txp(input logic w, input logic [15:0] d);
        tx_push = 1; tx_push_word = w; tx_push_data = d; cyc(); tx_push = 0; cyc();
    endtask

    task automatic rxp(input logic w, input logic [15:0] d);
        rx_push = 1; rx_push_word = w; rx_push_data = d; cyc(); rx_push = 0; cyc();
    endtask

    task automatic txq(input logic w, output logic [15:0] d);
        tx_pop = 1; tx_pop_word = w; #1; d = tx_pop_data; cyc(); tx_pop = 0; cyc();
    endtask

    task automatic rxq(input logic w, output logic [15:0] d);
        rx_pop = 1; rx_pop_word = w; #1; d = rx_pop_data; cyc(); rx_pop = 0; cyc();
    endtask

    initial begin
        logic [15:0] d;
        int lim;
        #1;
        cyc(); cyc();
        rst_n = 1;
        cyc();

        // reset state
        chk(ctrl_rdata, 0, "R1 reset ctrl");
        chk(tx_level, 0, "R2 reset tx level");
        chk(rx_level, 0, "R2 reset rx level");
        chk(tx_empty, 1, "R7 reset tx_empty");
        chk(rx_avail, 0, "R7 reset rx_avail");
        chk(irq, 0, "R12 reset irq");

        // R1 register layout and reserved bits
        wctrl(8'hFF);
        chk(ctrl_rdata, 8'h3F, "R1 reserved bits read 0");
        wctrl(8'hA4);
        chk(ctrl_rdata, 8'h24, "R1 stored fields");

        // R5 transmit watermark sweep, bytes
        for (int tm = 0; tm < 2; tm++) begin
            wctrl(8'((tm << 5) | 1));
            lim = tm ? 32 : 16;
            for (int k = 1; k <= 8; k++) begin
                txp(0, 16'(k * 3 + tm));
                chk(tx_level, 8 * k, "R2 tx byte level");
                chk(tx_near_empty, (8 * k <= lim) ? 1 : 0, "R5 tx near-empty");
                chk(tx_empty, 0, "R7 tx not empty");
            end
            chk(tx_overflow, tm, "R3 overflow before full push");
            txp(0, 16'hEE);
            chk(tx_level, 64, "R3 full push ignored");
            chk(tx_overflow, 1, "R3 overflow sticky");
            for (int k = 1; k <= 8; k++) begin
                txq(0, d);
                chk(d, k * 3 + tm, "R2 tx byte order");
                chk(tx_level, 64 - 8 * k, "R2 tx level after pop");
                chk(tx_near_empty, (64 - 8 * k <= lim) ? 1 : 0, "R5 tx near-empty drain");
            end
            chk(tx_underflow, tm, "R4 underflow before empty pop");
            txq(0, d);
            chk(tx_level, 0, "R4 empty pop ignored");
            chk(tx_underflow, 1, "R4 underflow sticky");
        end

        // R6 receive watermark sweep, words
        for (int rm = 0; rm < 2; rm++) begin
            wctrl(8'((rm << 4) | 1));
            lim = rm ? 32 : 48;
            for (int k = 1; k <= 4; k++) begin
                rxp(1, 16'(16'h1100 * k + rm));
                chk(rx_level, 16 * k, "R2 rx word level");
                chk(rx_near_full, (16 * k >= lim) ? 1 : 0, "R6 rx near-full");
                chk(rx_avail, 1, "R7 rx avail");
            end
            rxp(1, 16'hBEEF);
            chk(rx_level, 64, "R3 rx full push ignored");
            chk(rx_overflow, 1, "R3 rx overflow sticky");
            for (int k = 1; k <= 4; k++) begin
                rxq(1, d);
                chk(d, 16'h1100 * k + rm, "R2 rx word order");
                chk(rx_near_full, (64 - 16 * k >= lim) ? 1 : 0, "R6 rx near-full drain");
            end
            chk(rx_avail, 0, "R7 rx empty");
            rxq(1, d);
            chk(rx_underflow, 1, "R4 rx underflow sticky");
        end

        // R2 mixed byte/word ordering
        rxp(0, 16'h00A1);
        rxp(1, 16'hC3B2);
        rxq(1, d);
        chk(d, 16'hB2A1, "R2 word pop spans bytes");
        rxq(0, d);
        chk(d, 16'h00C3, "R2 byte pop upper zero");

        // R13 flush on mode change, R3 buffer capacity
        txp(0, 16'h11);
        rxp(0, 16'h22);
        wctrl(8'h00);
        chk(tx_level, 0, "R13 tx flushed");
        chk(rx_level, 0, "R13 rx flushed");
        txp(1, 16'h3344);
        chk(tx_level, 16, "R3 buffer mode word fits");
        txp(0, 16'h55);
        chk(tx_level, 16, "R3 buffer mode limit 16 bits");
        txq(1, d);
        chk(d, 16'h3344, "R2 buffer mode data");

        // R8 watermark enables ignored without FIFO mode
        wctrl(8'h06);
        chk(tx_near_empty, 1, "R8 near flag live");
        chk(irq, 0, "R8 enables ignored");
        wctrl(8'h07);
        chk(irq, 1, "R8 enables effective in FIFO mode");

        // R9 auto-clear follows flag
        wctrl(8'h05);
        txp(0, 1); txp(0, 2); txp(0, 3);
        chk(irq_pending[2], 0, "R9 pending follows flag low");
        chk(irq, 0, "R9 irq drops");
        txq(0, d);
        chk(irq_pending[2], 1, "R9 pending follows flag high");
        txq(0, d); txq(0, d);

        // R10 write-to-clear
        wctrl(8'h1B);
        wclr(4'hF);
        chk(irq_pending, 0, "R10 all cleared");
        rxp(1, 16'h0102);
        rxp(1, 16'h0304);
        chk(irq_pending[3], 1, "R10 nearly-full latched");
        chk(irq, 1, "R12 irq from nearly-full");
        rxq(0, d);
        chk(rx_near_full, 0, "R6 flag dropped");
        chk(irq_pending[3], 1, "R10 held after flag drop");
        chk(irq_pending[0], 1, "R10 data-available latched");
        wclr(4'h8);
        chk(irq_pending[3], 0, "R10 cleared by write");
        chk(irq_pending[0], 1, "R10 other bit untouched");

        // R11 clear in the same cycle as a new rise
        rx_push = 1; rx_push_word = 0; rx_push_data = 16'h77; cyc();
        rx_push = 0; clr_we = 1; clr_wdata = 4'h8; cyc();
        clr_we = 0; clr_wdata = 0; cyc();
        chk(irq_pending[3], 1, "R11 rise wins over clear");
        wclr(4'h8);
        chk(irq_pending[3], 0, "R11 later clear works");

        // R12 enable combination
        wctrl(8'h19);
        chk(irq, 0, "R12 no enables");
        rx_data_ie = 1; #1;
        chk(irq, 1, "R12 data-available enable");
        wclr(4'h1);
        chk(irq, 0, "R12 cleared source masked out");
        rx_data_ie = 0;

        summary();
        $finish;
    end

endmodule